// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synchronous static memory with an internal burst counter. Address, write data and control are registered on the rising clock edge. Read data comes from the array through no output register, so the word for an address taken in at an edge is on the output bus during the cycle that follows that edge. A single strobed address can supply four beats. A two-bit counter produces the three follow-on addresses, and the order is either linear or interleaved.

There are two address strobes, one for a processor and one for a cache controller. An access starts when either strobe is low while the chip is selected. It ends when a strobe arrives while the chip is not selected. Writes are decided one byte lane (nine bits) at a time, through a global write, a byte-write enable and per-lane selects. The data bus is either 36 bits (four lanes) or 18 bits (two lanes). A sleep input blocks all activity. Data in and data out are separate buses. An output-valid flag marks the cycles in which the output bus carries array data.

Top module: `fts_burst_ram`

## Requirements
- R1: While reset is asserted and after its release, `rvalid_o` is low until an access has been started.
- R2: The chip is selected when `ce_n_i`=0, `cs_hi_i`=1 and `cs_lo_n_i`=0. When a strobe (`strb_proc_n_i` or `strb_ctrl_n_i` low) samples a selected chip at a rising edge, the block loads `addr_i` and the counter. The word at that address is on `rdata_o`, with `rvalid_o`=1, in the cycle after that edge.
- R3: With `burst_lin_i`=1 at the strobe, each edge that has `adv_n_i`=0 and no strobe moves the current address to low two bits (start+k) mod 4, for k=1,2,3. The upper address bits stay fixed.
- R4: With `burst_lin_i`=0 at the strobe, the follow-on low two bits are start XOR k, for k=1,2,3. The upper address bits stay fixed.
- R5: The counter wraps modulo 4, so a fourth advance returns to the start address. An edge with `adv_n_i`=1 and no strobe keeps the current address.
- R6: During an access, `gw_n_i`=0 at an edge writes all lanes of the address that the edge selects. The array is updated at the next edge.
- R7: When `gw_n_i`=1, `bwe_n_i`=0 together with `bsel_n_i[i]`=0 writes lane i, bits [9i+8:9i]. The other lanes keep their contents. When `bwe_n_i`=1, the cycle is a read.
- R8: With an 18-bit bus only `bsel_n_i[1:0]` take effect. `bsel_n_i[3:2]` write nothing.
- R9: An access started by the processor strobe is a read in its first cycle, whatever the write inputs are.
- R10: A strobe that samples a deselected chip ends the access. `rvalid_o` is low from the next cycle on, and advances and writes have no effect until a new access starts.
- R11: While `oe_n_i`=1, `rvalid_o` is low and `rdata_o` is zero, with no clock edge involved.
- R12: While `sleep_i`=1, `rvalid_o` drops at once, and edges neither start, advance, end nor write.
- R13: In the cycle after an edge that scheduled a write, `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Access start address |
| ce_n_i | input | 1 | Chip enable, active low |
| cs_hi_i | input | 1 | Chip select, active high |
| cs_lo_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| strb_proc_n_i | input | 1 | Processor address strobe, active low |
| strb_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | 4 | Per-lane write selects, active low |
| sleep_i | input | 1 | Sleep, asynchronous, active high |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
Address and control take effect at the rising edge that samples them, and read data is due one nanosecond after that edge, in the same cycle. The bench therefore drives inputs, waits for the edge and samples one nanosecond later. Each write is committed at the following edge. The bench reads a written word back through a new strobe one cycle later, when the commit and the new address coincide. Output enable and sleep act without a clock, so their checks sample one nanosecond after the input changes, with no edge in between.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
   localparam int unsigned BEATS  = 4;
   localparam int unsigned LANE_W = 9;

   typedef enum logic [1:0] {CY_NONE, CY_LOAD, CY_DROP, CY_STEP} cyc_e;

   // low address bits of beat cnt in a burst beginning at start
   function automatic logic [1:0] beat_ofs(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       lin);
      return lin ? 2'(start + cnt) : (start ^ cnt);
   endfunction
endpackage

// File: rtl/fts_burst_seq.sv
`timescale 1ns/1ps
module fts_burst_seq #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              drop_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              lin_i,
   output logic              active_o,
   output logic              lin_o,
   output logic [ADDR_W-1:0] cur_o
);
   import fts_pkg::*;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic              lin_q;
   logic              act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         lin_q  <= 1'b1;
         act_q  <= 1'b0;
      end else if (load_i) begin
         base_q <= addr_i;
         cnt_q  <= '0;
         lin_q  <= lin_i;
         act_q  <= 1'b1;
      end else if (drop_i) begin
         act_q  <= 1'b0;
      end else if (step_i) begin
         cnt_q  <= cnt_q + 2'd1;
      end
   end

   assign active_o = act_q;
   assign lin_o    = lin_q;
   assign cur_o    = {base_q[ADDR_W-1:2], beat_ofs(base_q[1:0], cnt_q, lin_q)};
endmodule

// File: rtl/fts_lane_dec.sv
`timescale 1ns/1ps
module fts_lane_dec #(
   parameter int unsigned LANES = 4
) (
   input  logic             gw_n_i,
   input  logic             bwe_n_i,
   input  logic [LANES-1:0] sel_n_i,
   output logic [LANES-1:0] mask_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask_o[g] = !gw_n_i || (!bwe_n_i && !sel_n_i[g]);
   end
endmodule

// File: rtl/fts_lane_ram.sv
`timescale 1ns/1ps
module fts_lane_ram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we_i,
   input  logic [ADDR_W-1:0]       waddr_i,
   input  logic [LANES*LANE_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]       raddr_i,
   output logic [LANES*LANE_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
      assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
   end
endmodule

// File: rtl/fts_burst_ram.sv
`timescale 1ns/1ps
module fts_burst_ram #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              cs_hi_i,
   input  logic              cs_lo_n_i,
   input  logic              oe_n_i,
   input  logic              strb_proc_n_i,
   input  logic              strb_ctrl_n_i,
   input  logic              adv_n_i,
   input  logic              burst_lin_i,
   input  logic              gw_n_i,
   input  logic              bwe_n_i,
   input  logic [3:0]        bsel_n_i,
   input  logic              sleep_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);
   import fts_pkg::*;

   localparam int unsigned LANES = DATA_W / LANE_W;

   if ((DATA_W % LANE_W) != 0 || (LANES != 2 && LANES != 4)) begin : g_bad_width
      $error("fts_burst_ram: DATA_W must be 18 or 36");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("fts_burst_ram: ADDR_W must be at least 3");
   end

   logic [LANES-1:0] sel_n;
   if (LANES < 4) begin : g_narrow
      logic unused_sel;
      assign unused_sel = ^bsel_n_i[3:LANES];
   end
   assign sel_n = bsel_n_i[LANES-1:0];

   logic sel, strb, awake;
   assign sel   = !ce_n_i && cs_hi_i && !cs_lo_n_i;
   assign strb  = !strb_proc_n_i || !strb_ctrl_n_i;
   assign awake = !sleep_i;

   logic              seq_active, seq_lin;
   logic [ADDR_W-1:0] cur_addr;
   cyc_e              cyc;

   always_comb begin
      if (!awake)                     cyc = CY_NONE;
      else if (strb && sel)           cyc = CY_LOAD;
      else if (strb)                  cyc = CY_DROP;
      else if (seq_active && !adv_n_i) cyc = CY_STEP;
      else                            cyc = CY_NONE;
   end

   fts_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (cyc == CY_LOAD),
      .drop_i   (cyc == CY_DROP),
      .step_i   (cyc == CY_STEP),
      .addr_i   (addr_i),
      .lin_i    (burst_lin_i),
      .active_o (seq_active),
      .lin_o    (seq_lin),
      .cur_o    (cur_addr)
   );

   logic [LANES-1:0] dec_mask, mask_d, wr_q;
   logic [DATA_W-1:0] wdata_q, rd_word;
   logic wr_ok, wr_busy;

   fts_lane_dec #(.LANES(LANES)) u_dec (
      .gw_n_i  (gw_n_i),
      .bwe_n_i (bwe_n_i),
      .sel_n_i (sel_n),
      .mask_o  (dec_mask)
   );

   // processor-strobed start is a read; otherwise write while an access runs
   assign wr_ok  = awake && ((cyc == CY_LOAD && strb_proc_n_i) || (seq_active && !strb));
   assign mask_d = wr_ok ? dec_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= '0;
         wdata_q <= '0;
      end else begin
         wr_q    <= mask_d;
         wdata_q <= wdata_i;
      end
   end
   assign wr_busy = |wr_q;

   fts_lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
      .clk     (clk),
      .we_i    (wr_q),
      .waddr_i (cur_addr),
      .wdata_i (wdata_q),
      .raddr_i (cur_addr),
      .rdata_o (rd_word)
   );

   assign rvalid_o = seq_active && !oe_n_i && awake && !wr_busy;
   assign rdata_o  = rvalid_o ? rd_word : '0;
endmodule

// File: rtl/fts_burst_ram_chk.sv
`timescale 1ns/1ps
module fts_burst_ram_chk #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_i,
   input logic              oe_n_i,
   input logic              adv_n_i,
   input logic              strb_proc_n_i,
   input logic              strb_ctrl_n_i,
   input logic              gw_n_i,
   input logic              sel,
   input logic              seq_active,
   input logic              seq_lin,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              wr_busy,
   input logic              rvalid_o,
   input logic [DATA_W-1:0] rdata_o
);
   logic no_strb;
   assign no_strb = strb_proc_n_i && strb_ctrl_n_i;

   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> !rvalid_o);

   assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && no_strb && !adv_n_i && seq_active && seq_lin) |=>
      (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

   assert_ilv_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && no_strb && !adv_n_i && seq_active && !seq_lin) |=>
      (cur_addr[1:0] != $past(cur_addr[1:0])) &&
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && no_strb && adv_n_i) |=> $stable(cur_addr));

   assert_proc_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !strb_proc_n_i && sel) |=> !wr_busy);

   assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !no_strb && !sel) |=> !rvalid_o);

   assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> (!rvalid_o && rdata_o == '0));

   assert_sleep_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !rvalid_o);

   assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> ($stable(cur_addr) && !wr_busy));

   assert_write_blank_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !strb_ctrl_n_i && strb_proc_n_i && sel && !gw_n_i) |=> !rvalid_o);
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep_i       (sleep_i),
   .oe_n_i        (oe_n_i),
   .adv_n_i       (adv_n_i),
   .strb_proc_n_i (strb_proc_n_i),
   .strb_ctrl_n_i (strb_ctrl_n_i),
   .gw_n_i        (gw_n_i),
   .sel           (sel),
   .seq_active    (seq_active),
   .seq_lin       (seq_lin),
   .cur_addr      (cur_addr),
   .wr_busy       (wr_busy),
   .rvalid_o      (rvalid_o),
   .rdata_o       (rdata_o)
);

// File: tb/test_fts_burst_ram.sv
`timescale 1ns/1ps
module test_fts_burst_ram;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic ce_n, cs_hi, cs_lo_n, oe_n, sp_n, sc_n, adv_n, lin, gw_n, bwe_n, sleep;
   logic [3:0]  bsel_n;
   logic [35:0] wd;
   logic [35:0] rd_w;
   logic [17:0] rd_n;
   logic        rv_w, rv_n;

   logic [35:0] r36 [DEPTH];
   logic [17:0] r18 [DEPTH];

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   fts_burst_ram #(.ADDR_W(AW), .DATA_W(36)) i_fts_burst_ram (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .cs_hi_i(cs_hi),
      .cs_lo_n_i(cs_lo_n), .oe_n_i(oe_n), .strb_proc_n_i(sp_n), .strb_ctrl_n_i(sc_n),
      .adv_n_i(adv_n), .burst_lin_i(lin), .gw_n_i(gw_n), .bwe_n_i(bwe_n),
      .bsel_n_i(bsel_n), .sleep_i(sleep), .wdata_i(wd), .rdata_o(rd_w), .rvalid_o(rv_w));

   fts_burst_ram #(.ADDR_W(AW), .DATA_W(18)) i_fts_burst_ram_narrow (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n), .cs_hi_i(cs_hi),
      .cs_lo_n_i(cs_lo_n), .oe_n_i(oe_n), .strb_proc_n_i(sp_n), .strb_ctrl_n_i(sc_n),
      .adv_n_i(adv_n), .burst_lin_i(lin), .gw_n_i(gw_n), .bwe_n_i(bwe_n),
      .bsel_n_i(bsel_n), .sleep_i(sleep), .wdata_i(wd[17:0]), .rdata_o(rd_n), .rvalid_o(rv_n));

   function automatic logic [35:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
      return {salt, 4'hC, a, ~a, a, ~a};
   endfunction

   task automatic chk(input string tag, input logic [36:0] act, input logic [36:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; oe_n = 1'b0;
      sp_n = 1'b1; sc_n = 1'b1; adv_n = 1'b1; lin = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF; sleep = 1'b0;
   endtask

   task automatic read_ok(input string tag, input logic [AW-1:0] a);
      chk({tag, " wide"},   {rv_w, rd_w},         {1'b1, r36[a]});
      chk({tag, " narrow"}, {19'(rv_n), rd_n},    {19'h1, r18[a]});
   endtask

   task automatic start_read(input logic [AW-1:0] a, input logic order);
      idle(); addr = a; lin = order; sp_n = 1'b0;
      tick();
      idle();
   endtask

   task automatic t_reset();
      idle(); addr = '0; wd = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 in reset wide",   {36'd0, rv_w}, 37'd0);
      chk("R1 in reset narrow", {36'd0, rv_n}, 37'd0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset", {35'd0, rv_w, rv_n}, 37'd0);
   endtask

   task automatic t_fill();
      for (int a = 0; a < DEPTH; a++) begin
         idle(); addr = AW'(a); sc_n = 1'b0; gw_n = 1'b0; wd = pat(AW'(a), 8'h3C);
         tick();
         r36[a] = wd; r18[a] = wd[17:0];
      end
      idle();
      tick();
   endtask

   task automatic t_burst(input logic order);
      for (int s = 0; s < 4; s++) begin
         logic [AW-1:0] base;
         base = AW'(16 + 8 * s + s);
         start_read(base, order);
         read_ok("R2 first beat", base);
         for (int k = 1; k < 4; k++) begin
            logic [1:0] o;
            o = order ? 2'(s + k) : (2'(s) ^ 2'(k));
            adv_n = 1'b0;
            tick();
            read_ok(order ? "R3 linear beat" : "R4 interleaved beat", {base[AW-1:2], o});
         end
         tick();
         read_ok("R5 wrap to start", base);
         adv_n = 1'b1;
         tick();
         read_ok("R5 hold", base);
      end
   endtask

   task automatic t_bytes();
      logic [4:0] masks [7];
      masks = '{5'h01, 5'h02, 5'h04, 5'h08, 5'h05, 5'h0C, 5'h10};
      for (int i = 0; i < 7; i++) begin
         logic [AW-1:0] a;
         logic [35:0]   d;
         a = AW'(40 + i);
         d = pat(a, 8'(8'hA0 + i));
         idle(); addr = a; sc_n = 1'b0; wd = d;
         if (masks[i][4]) begin
            bwe_n = 1'b1; bsel_n = 4'h0;
         end else begin
            bwe_n = 1'b0; bsel_n = ~masks[i][3:0];
         end
         tick();
         if (!masks[i][4]) chk("R13 write cycle blank", {36'd0, rv_w}, 37'd0);
         if (!masks[i][4]) begin
            for (int l = 0; l < 4; l++)
               if (masks[i][l]) r36[a][l*9 +: 9] = d[l*9 +: 9];
            for (int l = 0; l < 2; l++)
               if (masks[i][l]) r18[a][l*9 +: 9] = d[l*9 +: 9];
         end
         start_read(a, 1'b1);
         read_ok(masks[i][4] ? "R7 bwe high reads" :
                 (masks[i][3:2] != 0 ? "R8 lane mask" : "R7 lane mask"), a);
      end
   endtask

   task automatic t_proc_read();
      idle(); addr = AW'(5); sp_n = 1'b0; sc_n = 1'b0; gw_n = 1'b0; wd = 36'hFFFFFFFFF;
      tick();
      read_ok("R9 proc strobe read", AW'(5));
      idle();
      tick();
      read_ok("R9 no write after", AW'(5));
   endtask

   task automatic t_global_write();
      idle(); addr = AW'(9); sc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; wd = pat(AW'(9), 8'h77);
      tick();
      r36[9] = wd; r18[9] = wd[17:0];
      start_read(AW'(9), 1'b1);
      read_ok("R6 global write", AW'(9));
   endtask

   task automatic t_deselect();
      start_read(AW'(12), 1'b1);
      read_ok("R10 before deselect", AW'(12));
      idle(); ce_n = 1'b1; sc_n = 1'b0;
      tick();
      chk("R10 deselected", {35'd0, rv_w, rv_n}, 37'd0);
      idle(); adv_n = 1'b0; gw_n = 1'b0; wd = 36'h123456789;
      tick();
      chk("R10 advance ignored", {35'd0, rv_w, rv_n}, 37'd0);
      start_read(AW'(12), 1'b1);
      read_ok("R10 no write while deselected", AW'(12));
      start_read(AW'(13), 1'b1);
      read_ok("R10 neighbour untouched", AW'(13));
   endtask

   task automatic t_oe();
      start_read(AW'(20), 1'b1);
      oe_n = 1'b1;
      #1;
      chk("R11 oe off wide",   {rv_w, rd_w}, 37'd0);
      chk("R11 oe off narrow", {19'(rv_n), rd_n}, 37'd0);
      oe_n = 1'b0;
      #1;
      read_ok("R11 oe back", AW'(20));
   endtask

   task automatic t_sleep();
      start_read(AW'(24), 1'b1);
      sleep = 1'b1;
      #1;
      chk("R12 sleep gates output", {35'd0, rv_w, rv_n}, 37'd0);
      addr = AW'(30); sc_n = 1'b0; gw_n = 1'b0; adv_n = 1'b0; wd = 36'h0DEADBEEF;
      tick();
      chk("R12 asleep after edge", {35'd0, rv_w, rv_n}, 37'd0);
      idle();
      #1;
      read_ok("R12 address held", AW'(24));
      start_read(AW'(30), 1'b1);
      read_ok("R12 no write in sleep", AW'(30));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_burst(1'b1);
      t_burst(1'b0);
      t_global_write();
      t_bytes();
      t_proc_read();
      t_deselect();
      t_oe();
      t_sleep();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule